// File: doc/BRIEF.md
# Cascaded DMA Request Arbiter

This block arbitrates between two four-channel DMA request groups arranged as a two-level tree. The upstream group never asks the bus master for the bus directly. Instead, any eligible upstream channel raises a cascade request. That request occupies one fixed channel slot (the cascade slot, channel 0 by default) of the root group. Only the root group drives the single hold-request line to the bus master.

When the bus master answers with hold-acknowledge, the block picks a winner, registers it and drives a one-hot acknowledge. If the root winner is the cascade slot, the root acknowledge goes to that slot and the upstream winner is acknowledged as well. The granted controller and channel are reported, and they stay frozen until terminal count ends the service or the bus master withdraws hold-acknowledge.

Priority is fixed, with channel 0 highest. Register programming, address generation and data movement are handled elsewhere: masks and requests arrive as plain inputs, and terminal count arrives as a pulse from the transfer engine.

Top module: `dma_casc_arb`

## Requirements
- R1: A channel is eligible only when its request bit is 1 and its mask bit is 0; a masked request never produces a hold request, a cascade request or an acknowledge.
- R2: Within each group, the eligible channel with the lowest index wins (index 0 highest).
- R3: `cascade_req` is registered: one cycle after any upstream channel is eligible it is 1, and one cycle after none is eligible it is 0.
- R4: The root request input bit at the cascade slot (bit 0) is ignored; that slot's request is the upstream-eligible OR, still subject to `root_mask` bit 0.
- R5: Outside a grant, `hold_req` is 1 one cycle after the root group has an eligible channel and 0 one cycle after it has none.
- R6: On a clock edge where `hold_ack` and `hold_req` are both 1, there is no grant and a root channel other than the cascade slot wins, the next cycle shows `grant_valid`=1, `grant_up`=0, `grant_ch` = that channel and `root_ack` one-hot on it, with `up_ack`=0.
- R7: If the root winner at that edge is the cascade slot, the next cycle shows `root_ack` bit 0 set, `up_ack` one-hot on the upstream winner, `grant_up`=1 and `grant_ch` = the upstream channel.
- R8: If no channel is eligible at the acknowledge edge, no grant is issued. A grant follows automatically once a channel becomes eligible again while `hold_ack` stays 1.
- R9: While granted, `grant_ch`, `grant_up` and the acknowledges stay unchanged even if higher-priority requests arrive or masks change.
- R10: `tc`=1 during a grant drops all acknowledges and `grant_valid` and forces `hold_req` to 0 on the next cycle. If the grant came through the cascade, `cascade_req` is also 0 on that cycle.
- R11: `tc` has no effect when no grant is active.
- R12: `hold_ack`=0 during a grant ends the grant on the next cycle without forcing `hold_req` low.
- R13: `hold_req` stays 1 for the whole grant.
- R14: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | NCH | Upstream group pending requests |
| up_mask | input | NCH | Upstream group masks (1 = blocked) |
| root_req | input | NCH | Root group pending requests (cascade bit ignored) |
| root_mask | input | NCH | Root group masks (1 = blocked) |
| hold_ack | input | 1 | Hold acknowledge from bus master |
| tc | input | 1 | Terminal count of the granted transfer |
| hold_req | output | 1 | Hold request to bus master |
| cascade_req | output | 1 | Upstream request folded into the cascade slot |
| up_ack | output | NCH | One-hot upstream acknowledge |
| root_ack | output | NCH | One-hot root acknowledge |
| grant_valid | output | 1 | A grant is active |
| grant_up | output | 1 | Grant belongs to the upstream group |
| grant_ch | output | CW | Granted channel within its group |

## Verification
The bench sweeps every upstream request/mask pair against arithmetically varied root patterns, and then sweeps every root request/mask pair against varied upstream patterns. This separates masking from requesting, root winners from cascade winners, and the ignored cascade input bit from real root requests. Each case then injects all-ones requests during the grant to show the frozen identity, and ends the grant with terminal count to expose the cascade-specific release. Directed sequences cover terminal count outside a grant, withdrawal of acknowledge, and the wait while all channels are masked.

// File: rtl/dma_casc_pkg.sv
package dma_casc_pkg;
   typedef enum logic {
      GR_IDLE = 1'b0,
      GR_BUSY = 1'b1
   } gr_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dma_casc_prio.sv
module dma_casc_prio #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  vec,
   output logic          hit,
   output logic [IW-1:0] idx
);
   generate
      if (N == 1) begin : g_single
         assign hit = vec[0];
         assign idx = '0;
      end else begin : g_scan
         always_comb begin
            hit = |vec;
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (vec[i]) idx = IW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dma_casc_ackdec.sv
module dma_casc_ackdec #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          en,
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  onehot
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_bit
         assign onehot[g] = en && (idx == IW'(g));
      end
   endgenerate
endmodule

// File: rtl/dma_casc_arb.sv
module dma_casc_arb
   import dma_casc_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int CASC_CH = 0,
   localparam int CW     = idx_width(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] up_req,
   input  logic [NCH-1:0] up_mask,
   input  logic [NCH-1:0] root_req,
   input  logic [NCH-1:0] root_mask,
   input  logic           hold_ack,
   input  logic           tc,
   output logic           hold_req,
   output logic           cascade_req,
   output logic [NCH-1:0] up_ack,
   output logic [NCH-1:0] root_ack,
   output logic           grant_valid,
   output logic           grant_up,
   output logic [CW-1:0]  grant_ch
);
   generate
      if (NCH < 2 || NCH > 16) begin : g_bad_nch
         $error("dma_casc_arb: NCH out of range");
      end
      if (CASC_CH < 0 || CASC_CH >= NCH) begin : g_bad_casc
         $error("dma_casc_arb: CASC_CH out of range");
      end
   endgenerate

   localparam logic [CW-1:0] CASC_IDX = CW'(CASC_CH);

   logic [NCH-1:0] up_elig, root_in, root_elig;
   logic           casc_now;
   logic           up_hit, root_hit;
   logic [CW-1:0]  up_idx, root_idx;
   logic           pick_valid, pick_up;
   logic [CW-1:0]  pick_ch;
   logic           take, finish, abort;

   gr_state_e      st_q;
   logic           gup_q;
   logic [CW-1:0]  gch_q;
   logic           hold_q, casc_q;

   assign up_elig  = up_req & ~up_mask;
   assign casc_now = |up_elig;

   always_comb begin
      root_in          = root_req;
      root_in[CASC_CH] = casc_now;
   end
   assign root_elig = root_in & ~root_mask;

   dma_casc_prio #(.N(NCH), .IW(CW)) u_up_prio (
      .vec (up_elig),
      .hit (up_hit),
      .idx (up_idx)
   );

   dma_casc_prio #(.N(NCH), .IW(CW)) u_root_prio (
      .vec (root_elig),
      .hit (root_hit),
      .idx (root_idx)
   );

   assign pick_up    = (root_idx == CASC_IDX);
   assign pick_valid = root_hit && (!pick_up || up_hit);
   assign pick_ch    = pick_up ? up_idx : root_idx;

   assign take   = (st_q == GR_IDLE) && hold_ack && hold_q && pick_valid;
   assign finish = (st_q == GR_BUSY) && tc;
   assign abort  = (st_q == GR_BUSY) && !hold_ack && !tc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= GR_IDLE;
         gup_q  <= 1'b0;
         gch_q  <= '0;
         hold_q <= 1'b0;
         casc_q <= 1'b0;
      end else begin
         if (take) begin
            st_q  <= GR_BUSY;
            gup_q <= pick_up;
            gch_q <= pick_ch;
         end else if (finish || abort) begin
            st_q <= GR_IDLE;
         end

         if (finish)
            hold_q <= 1'b0;
         else if (take || ((st_q == GR_BUSY) && !abort))
            hold_q <= 1'b1;
         else
            hold_q <= |root_elig;

         if (finish && gup_q)
            casc_q <= 1'b0;
         else
            casc_q <= casc_now;
      end
   end

   logic           busy;
   logic [CW-1:0]  root_sel;

   assign busy     = (st_q == GR_BUSY);
   assign root_sel = gup_q ? CASC_IDX : gch_q;

   dma_casc_ackdec #(.N(NCH), .IW(CW)) u_root_dec (
      .en     (busy),
      .idx    (root_sel),
      .onehot (root_ack)
   );

   dma_casc_ackdec #(.N(NCH), .IW(CW)) u_up_dec (
      .en     (busy && gup_q),
      .idx    (gch_q),
      .onehot (up_ack)
   );

   assign hold_req    = hold_q;
   assign cascade_req = casc_q;
   assign grant_valid = busy;
   assign grant_up    = gup_q;
   assign grant_ch    = gch_q;
endmodule

// File: rtl/dma_casc_arb_chk.sv
module dma_casc_arb_chk #(
   parameter int NCH     = 4,
   parameter int CASC_CH = 0,
   parameter int CW      = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] up_req,
   input logic [NCH-1:0] up_mask,
   input logic [NCH-1:0] root_req,
   input logic [NCH-1:0] root_mask,
   input logic           hold_ack,
   input logic           tc,
   input logic           hold_req,
   input logic           cascade_req,
   input logic [NCH-1:0] up_ack,
   input logic [NCH-1:0] root_ack,
   input logic           grant_valid,
   input logic           grant_up,
   input logic [CW-1:0]  grant_ch
);
   logic           up_any;
   logic [NCH-1:0] r_elig;

   assign up_any = |(up_req & ~up_mask);
   always_comb begin
      r_elig          = root_req;
      r_elig[CASC_CH] = up_any;
      r_elig          = r_elig & ~root_mask;
   end

   p_casc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (up_any && !(grant_valid && tc && grant_up)) |=> cascade_req);
   p_casc_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !up_any |=> !cascade_req);
   p_hold_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_valid && (|r_elig)) |=> hold_req);
   p_hold_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_valid && !(|r_elig)) |=> !hold_req);
   p_root_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(root_ack) && (grant_valid == (|root_ack)));
   p_grant_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_valid) |-> $past(hold_ack) && $past(hold_req));
   p_up_via_casc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|up_ack) |-> (root_ack[CASC_CH] && grant_up && $onehot(up_ack)));
   p_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && hold_ack && !tc) |=>
         (grant_valid && $stable(grant_ch) && $stable(grant_up)));
   p_tc_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && tc) |=> (!hold_req && !grant_valid && root_ack == '0));
   p_tc_casc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && tc && grant_up) |=> (!cascade_req && up_ack == '0));
   p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !hold_ack) |=> !grant_valid);
   p_hold_in_grant_r13: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> hold_req);
endmodule

bind dma_casc_arb dma_casc_arb_chk #(.NCH(NCH), .CASC_CH(CASC_CH), .CW(CW)) u_chk (.*);

// File: tb/dma_casc_arb_bench.sv
module dma_casc_arb_bench;
   localparam int NCH = 4;
   localparam int CW  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] up_req = '0, up_mask = '0, root_req = '0, root_mask = '0;
   logic           hold_ack = 1'b0, tc = 1'b0;
   logic           hold_req, cascade_req, grant_valid, grant_up;
   logic [NCH-1:0] up_ack, root_ack;
   logic [CW-1:0]  grant_ch;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   dma_casc_arb #(.NCH(NCH), .CASC_CH(0)) u_dma_casc_arb (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int lowbit(input int v);
      for (int i = 0; i < NCH; i++) if (v[i]) return i;
      return -1;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic run_case(input int ur, input int um, input int rr, input int rm);
      int ue, re, rw, uw, exp_root, exp_up, exp_ch;
      bit ce, ev, eu;
      @(negedge clk);
      up_req = 4'(ur); up_mask = 4'(um); root_req = 4'(rr); root_mask = 4'(rm);
      hold_ack = 1'b0; tc = 1'b0;
      @(negedge clk);
      ue = ur & ~um & 15;
      ce = (ue != 0);
      re = ((rr & 14) | int'(ce)) & ~rm & 15;
      chk(cascade_req == ce, "R3 R1 cascade", cascade_req, ce);
      chk(hold_req == (re != 0), "R5 R4 hold", hold_req, re != 0);
      hold_ack = 1'b1;
      @(negedge clk);
      rw = lowbit(re);
      ev = (rw >= 0);
      eu = (rw == 0);
      uw = lowbit(ue);
      exp_ch   = !ev ? 0 : (eu ? uw : rw);
      exp_root = ev ? (1 << rw) : 0;
      exp_up   = (ev && eu) ? (1 << uw) : 0;
      chk(grant_valid == ev, "R6 R8 grant_valid", grant_valid, ev);
      chk(root_ack == 4'(exp_root), "R2 R6 root_ack", root_ack, exp_root);
      chk(up_ack == 4'(exp_up), "R2 R7 up_ack", up_ack, exp_up);
      if (ev) begin
         chk(grant_up == eu, "R7 grant_up", grant_up, eu);
         chk(grant_ch == 2'(exp_ch), "R2 grant_ch", grant_ch, exp_ch);
         up_req = '1; up_mask = '0; root_req = '1; root_mask = '0;
         @(negedge clk);
         chk(grant_valid && grant_ch == 2'(exp_ch) && grant_up == eu &&
             root_ack == 4'(exp_root), "R9 frozen grant", grant_ch, exp_ch);
         chk(hold_req == 1'b1, "R13 hold during grant", hold_req, 1);
         tc = 1'b1;
         @(negedge clk);
         chk(!grant_valid && root_ack == '0 && up_ack == '0, "R10 acks dropped",
             root_ack, 0);
         chk(hold_req == 1'b0, "R10 hold released", hold_req, 0);
         chk(cascade_req == !eu, "R10 cascade release", cascade_req, !eu);
         tc = 1'b0; hold_ack = 1'b0;
         up_req = '0; root_req = '0;
         @(negedge clk);
      end else begin
         hold_ack = 1'b0;
         up_req = '0; root_req = '0;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!hold_req && !cascade_req && !grant_valid && !grant_up &&
          up_ack == '0 && root_ack == '0 && grant_ch == '0, "R14 reset", hold_req, 0);
      rst_n = 1'b1;

      // R11: tc while idle leaves the pending hold request alone
      @(negedge clk);
      root_req = 4'b0100; tc = 1'b1;
      repeat (2) @(negedge clk);
      chk(hold_req == 1'b1, "R11 tc idle hold", hold_req, 1);
      chk(grant_valid == 1'b0, "R11 tc idle grant", grant_valid, 0);
      tc = 1'b0;

      // R12: withdrawing hold_ack ends the grant
      hold_ack = 1'b1;
      @(negedge clk);
      chk(grant_valid && root_ack == 4'b0100, "R12 grant ch2", root_ack, 4);
      hold_ack = 1'b0;
      @(negedge clk);
      chk(!grant_valid && root_ack == '0, "R12 grant ended", grant_valid, 0);
      chk(hold_req == 1'b1, "R12 hold kept", hold_req, 1);
      root_req = '0;
      repeat (2) @(negedge clk);

      // R8: all masked at acknowledge, grant follows unmask
      up_req = 4'b0001;
      @(negedge clk);
      chk(hold_req == 1'b1, "R8 hold before mask", hold_req, 1);
      up_mask = 4'b1111; hold_ack = 1'b1;
      @(negedge clk);
      chk(!grant_valid && up_ack == '0, "R8 no grant masked", grant_valid, 0);
      @(negedge clk);
      chk(hold_req == 1'b0, "R8 hold dropped", hold_req, 0);
      up_mask = '0;
      repeat (2) @(negedge clk);
      chk(grant_valid && up_ack == 4'b0001 && root_ack == 4'b0001,
          "R8 grant after unmask", up_ack, 1);
      tc = 1'b1;
      @(negedge clk);
      tc = 1'b0; hold_ack = 1'b0; up_req = '0;
      repeat (2) @(negedge clk);

      for (int a = 0; a < 256; a++)
         run_case(a & 15, a >> 4, ((a * 5) + 3) & 15, ((a >> 4) * 3 + 1) & 14);
      for (int a = 0; a < 256; a++)
         run_case((a * 7) & 15, ((a >> 3) * 5) & 15, a & 15, a >> 4);

      finish_run();
   end
endmodule